// File: doc/BRIEF.md
# Parallel EEPROM Byte Writer with Bit-7 Completion Polling

This block sits on the host side of a byte-wide parallel EEPROM. A requester hands it one address and one data byte. The block runs a single write cycle on the memory pins, then tracks the device's internal programming by reading that same address again and again until the programming is over.

While the device is still programming, a read of the byte just written returns bit 7 inverted. Once programming has finished, the read returns the true bit 7. The block therefore compares only bit 7 of each read-back with the bit 7 it wrote. It pauses for a programmable number of cycles between polls. It ends either when the bits agree, or with an error when a polling budget of `TIMEOUT_CYC` clock cycles runs out. The default budget is 10 ms at 200 MHz.

Each phase length is a count input, so the strobe widths meet the memory's limits at any clock rate: at least 150 ns of write strobe low, at least 50 ns of strobe high, and 100 ns of data setup before the strobe rises. The read wait must cover an output-enable access time of up to 85 ns. The data bus is split into an output byte, an output-enable and an input byte, which pad logic joins into one bidirectional bus.

Top module: `eeprom_poll_writer`

## Requirements
- R1: Out of reset `req_ready`=1, `mem_cs_n`=`mem_we_n`=`mem_oe_n`=1, `mem_dq_oe`=0, `done`=0 and `err`=0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1, which captures `req_addr` and `req_data`. When `req_ready` is 0, `req_valid` is ignored and the captured address and data stay unchanged.
- R3: The write cycle has three parts, in order:
  - a setup part of `cfg_setup`+1 cycles with `mem_cs_n`=0 and `mem_we_n`=1;
  - a strobe part of `cfg_pulse`+1 cycles with `mem_we_n`=0;
  - a hold part of `cfg_hold`+1 cycles with `mem_we_n`=1 and `mem_cs_n`=0.
- R4: `mem_dq_oe` is 1 exactly during the strobe and hold parts, `mem_dq_out` then equals the captured byte, and `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R5: Each poll is made of two parts:
  - a pause of `cfg_gap`+1 cycles with all three strobes at 1;
  - a read of `cfg_read`+1 cycles with `mem_cs_n`=`mem_oe_n`=0 and `mem_addr` equal to the captured address.
  `mem_dq_in` is sampled at the clock edge that ends the last read cycle.
- R6: If the sampled bit 7 equals bit 7 of the captured byte, the next cycle shows `done`=1 and `err`=0 for exactly one cycle. After that cycle `req_ready` returns to 1.
- R7: If the sampled bit 7 differs and the budget is not used up, a new pause and read follow at once.
- R8: The poll count of a read is the number of polling cycles from the first pause cycle through the last cycle of that read. If bit 7 differs on a read whose poll count is at least `TIMEOUT_CYC`, the next cycle shows `done`=1 and `err`=1 for one cycle, and `err` is never 1 without `done`.
- R9: `mem_we_n` and `mem_oe_n` are never 0 together, and `mem_cs_n` is 0 whenever either of them is 0.
- R10: Bits 6 to 0 of `mem_dq_in` have no effect on the completion decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_setup | input | CW | Setup length minus one, in cycles |
| cfg_pulse | input | CW | Write strobe low length minus one |
| cfg_hold | input | CW | Hold length minus one |
| cfg_gap | input | CW | Pause between polls minus one |
| cfg_read | input | CW | Read length minus one |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Byte address of the request |
| req_data | input | 8 | Byte to write |
| req_ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| mem_addr | output | AW | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
For a request taken at edge E0, the setup part is due in the first cycle after E0. The strobe part follows after another `cfg_setup`+1 cycles, and every later part lands at the running sum of the `cfg_*`+1 lengths. The `done` pulse is due exactly one cycle after the read whose sampled bit 7 decides the outcome.

The bench builds, per request, a queue of expected pin values for every cycle. It starts with the acceptance cycle and derives the poll outcomes from a device model that stays busy for a chosen number of cycles after the write strobe rises. The checker pops one entry at each falling edge, mid-cycle after all registers have settled. When the queue is empty, it expects the idle state.

// File: rtl/eepw_pkg.sv
`timescale 1ns/1ps
// Shared types for the EEPROM byte writer with completion polling.
package eepw_pkg;

    // Sequencer phases, in the order one request walks through them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PULSE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_GAP   = 3'd4,
        ST_READ  = 3'd5,
        ST_DONE  = 3'd6
    } eepw_state_t;

endpackage

// File: rtl/eepw_phase_timer.sv
`timescale 1ns/1ps
// Phase length counter.
// Counts cycles within the current phase and flags the last cycle, which is
// the cycle where the count equals the limit (so a phase lasts limit+1 cycles).
// Assumes the owner pulses restart on the last cycle of every phase and while idle.
module eepw_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Cycle count within the phase, cleared at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Final cycle of the phase.
    assign last = (cnt_q == limit);

endmodule

// File: rtl/eepw_poll_timer.sv
`timescale 1ns/1ps
// Polling budget counter.
// Counts the cycles spent polling since the write completed and reports when
// the cycle being spent is the TIMEOUT_CYC-th or later.
// Assumes TIMEOUT_CYC >= 1; the count saturates and never wraps.
module eepw_poll_timer #(
    parameter int TIMEOUT_CYC = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);

    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LAST_IDX = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] spent_q;

    // Polling cycles already spent, held at the limit once reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spent_q <= '0;
        end else if (clr) begin
            spent_q <= '0;
        end else if (en && !expired) begin
            spent_q <= spent_q + TW'(1);
        end
    end

    // The current cycle is at or beyond the budget.
    assign expired = (spent_q >= LAST_IDX);

endmodule

// File: rtl/eepw_pin_decode.sv
`timescale 1ns/1ps
// Memory pin decoder.
// Turns the sequencer phase into strobe levels and the data bus drive, and
// compares bit 7 of the byte on the bus with bit 7 of the byte written.
// Assumes the phase comes straight from a register, so the strobes change
// only at clock edges.
module eepw_pin_decode
    import eepw_pkg::*;
#(
    parameter int AW = 19
) (
    input  eepw_state_t   state,
    input  logic [AW-1:0] addr_q,
    input  logic [7:0]    data_q,
    input  logic [7:0]    dq_in,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    output logic          bit7_match
);

    logic unused_low_bits;

    // Strobe levels for each phase.
    always_comb begin
        mem_cs_n = 1'b1;
        mem_we_n = 1'b1;
        mem_oe_n = 1'b1;
        dq_oe    = 1'b0;
        unique case (state)
            ST_SETUP: begin
                mem_cs_n = 1'b0;
            end
            ST_PULSE: begin
                mem_cs_n = 1'b0;
                mem_we_n = 1'b0;
                dq_oe    = 1'b1;
            end
            ST_HOLD: begin
                mem_cs_n = 1'b0;
                dq_oe    = 1'b1;
            end
            ST_READ: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: begin
                mem_cs_n = 1'b1;
            end
        endcase
    end

    assign mem_addr   = addr_q;
    assign dq_out     = data_q;
    assign bit7_match = (dq_in[7] == data_q[7]);

    // The low bits play no part in the completion decision.
    assign unused_low_bits = ^dq_in[6:0];

endmodule

// File: rtl/eeprom_poll_writer.sv
`timescale 1ns/1ps
// EEPROM byte writer with bit-7 completion polling.
// Takes one address and data byte per request, runs a timed write cycle,
// then reads the same address after programmable pauses until bit 7 reads
// back true, or until the polling budget of TIMEOUT_CYC cycles is spent.
// Assumes the cfg_* inputs stay stable while a request is in progress.
module eeprom_poll_writer
    import eepw_pkg::*;
#(
    parameter int AW          = 19,
    parameter int CW          = 8,
    parameter int TIMEOUT_CYC = 2_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_pulse,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_gap,
    input  logic [CW-1:0] cfg_read,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          req_ready,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [7:0]    mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [7:0]    mem_dq_in
);

    eepw_state_t   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          err_q;
    logic [CW-1:0] phase_limit;
    logic          phase_last;
    logic          phase_restart;
    logic          poll_expired;
    logic          bit7_match;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Length of the phase now running.
    always_comb begin
        unique case (state_q)
            ST_SETUP: phase_limit = cfg_setup;
            ST_PULSE: phase_limit = cfg_pulse;
            ST_HOLD:  phase_limit = cfg_hold;
            ST_GAP:   phase_limit = cfg_gap;
            ST_READ:  phase_limit = cfg_read;
            default:  phase_limit = '0;
        endcase
    end

    assign phase_restart = phase_last || (state_q == ST_IDLE) || (state_q == ST_DONE);

    eepw_phase_timer #(
        .CW(CW)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(phase_restart),
        .limit  (phase_limit),
        .last   (phase_last)
    );

    eepw_poll_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == ST_HOLD),
        .en     ((state_q == ST_GAP) || (state_q == ST_READ)),
        .expired(poll_expired)
    );

    eepw_pin_decode #(
        .AW(AW)
    ) u_pins (
        .state     (state_q),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .dq_in     (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .dq_out    (mem_dq_out),
        .dq_oe     (mem_dq_oe),
        .bit7_match(bit7_match)
    );

    // Phase sequencing, including the poll decision at the end of each read.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)  state_d = ST_SETUP;
            ST_SETUP: if (phase_last) state_d = ST_PULSE;
            ST_PULSE: if (phase_last) state_d = ST_HOLD;
            ST_HOLD:  if (phase_last) state_d = ST_GAP;
            ST_GAP:   if (phase_last) state_d = ST_READ;
            ST_READ: begin
                if (phase_last) begin
                    if (bit7_match || poll_expired) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture, only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Outcome of the latest poll, reported with the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if ((state_q == ST_READ) && phase_last) begin
            err_q <= !bit7_match;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign err       = (state_q == ST_DONE) && err_q;

endmodule

// File: rtl/eepw_checker.sv
`timescale 1ns/1ps
// Protocol checker for the EEPROM byte writer, attached by bind.
// Watches the request handshake and the memory pins only.
module eepw_checker #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [7:0]    mem_dq_out,
    input logic          mem_dq_oe
);

    a_r9_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    a_r9_cs_covers_we: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    a_r5_cs_covers_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_cs_n);

    a_r4_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !mem_cs_n && mem_we_n));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

bind eeprom_poll_writer eepw_checker #(.AW(AW)) u_eepw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/eeprom_poll_writer_bench.sv
`timescale 1ns/1ps
// Bench: per-request expected pin queue, checked every cycle at the falling edge.
module eeprom_poll_writer_bench;

    localparam int AW  = 16;
    localparam int CW  = 6;
    localparam int TMO = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0, cfg_gap = '0, cfg_read = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_ready, done, err;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]    mem_dq_out;
    logic [7:0]    mem_dq_in = '0;

    always #2.5 clk = ~clk;

    eeprom_poll_writer #(.AW(AW), .CW(CW), .TIMEOUT_CYC(TMO)) u_eeprom_poll_writer (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .cfg_gap(cfg_gap), .cfg_read(cfg_read),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .done(done), .err(err),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    typedef struct {
        logic [6:0] pins;   // {cs_n, we_n, oe_n, dq_oe, ready, done, err}
        string      tag;
    } exp_t;

    exp_t          exp_q[$];
    int            n_cmp = 0;
    int            n_bad = 0;
    int            kpos;
    logic [AW-1:0] cur_addr = '0;
    logic [7:0]    cur_data = '0;
    bit            checking = 1'b0;

    // Device model: busy for dev_busy cycles after the write strobe rises.
    logic [7:0] dev_mem [int];
    logic [7:0] last_d = '0;
    logic [7:0] dev_junk = '0;
    int         dev_busy = 0;
    int         ncyc = 0;
    int         busy_until = 0;
    logic       prev_we = 1'b1;

    always @(negedge clk) begin
        if (prev_we == 1'b0 && mem_we_n == 1'b1) begin
            dev_mem[int'(mem_addr)] = mem_dq_out;
            last_d     = mem_dq_out;
            busy_until = ncyc + dev_busy;
        end
        prev_we = mem_we_n;
        if (ncyc < busy_until)
            mem_dq_in = {~last_d[7], last_d[6:0] ^ dev_junk[6:0]};
        else if (dev_mem.exists(int'(mem_addr)))
            mem_dq_in = dev_mem[int'(mem_addr)] ^ {1'b0, dev_junk[6:0]};
        else
            mem_dq_in = {1'b0, dev_junk[6:0]};
        ncyc++;
    end

    task automatic push(input logic [6:0] p, input string tag);
        exp_t e;
        e.pins = p;
        e.tag  = tag;
        exp_q.push_back(e);
        kpos++;
    endtask

    // Cycle-by-cycle checker.
    always @(negedge clk) begin
        exp_t e;
        logic [6:0] act;
        if (checking) begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else begin e.pins = 7'b1110100; e.tag = "R1"; end
            act = {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, done, err};
            n_cmp++;
            if (act !== e.pins) begin
                n_bad++;
                $display("FAIL %s pins {cs_n,we_n,oe_n,dq_oe,ready,done,err} actual %b expected %b",
                         e.tag, act, e.pins);
            end
            if (e.pins[3]) begin
                n_cmp++;
                if (mem_dq_out !== cur_data) begin
                    n_bad++;
                    $display("FAIL R4 dq_out actual %h expected %h", mem_dq_out, cur_data);
                end
            end
            if (!e.pins[6]) begin
                n_cmp++;
                if (mem_addr !== cur_addr) begin
                    n_bad++;
                    $display("FAIL R5 mem_addr actual %h expected %h", mem_addr, cur_addr);
                end
            end
            if (!mem_we_n && !mem_oe_n) begin
                n_bad++;
                $display("FAIL R9 we_n/oe_n actual 0/0 expected not both 0");
            end
        end
    end

    // One request: drive it, build the expected pin queue, wait for the end.
    task automatic run_write(input logic [AW-1:0] a, input logic [7:0] d,
                             input int s, input int p, input int h, input int g, input int r,
                             input int busy, input logic [7:0] junk, input bit poke,
                             input string done_tag);
        int  k_rise, j, ks;
        bit  first;
        @(posedge clk); #1;
        cfg_setup = CW'(s); cfg_pulse = CW'(p); cfg_hold = CW'(h);
        cfg_gap = CW'(g); cfg_read = CW'(r);
        dev_busy = busy; dev_junk = junk;
        cur_addr = a; cur_data = d;
        req_addr = a; req_data = d; req_valid = 1'b1;
        kpos = 0;
        push(7'b1110100, "R2");                              // acceptance cycle
        for (int i = 0; i <= s; i++) push(7'b0110000, "R3"); // setup
        for (int i = 0; i <= p; i++) push(7'b0011000, "R3"); // strobe low
        k_rise = kpos;
        for (int i = 0; i <= h; i++) push(7'b0111000, "R3"); // hold
        j = 0;
        first = 1'b1;
        forever begin
            for (int i = 0; i <= g; i++) begin
                push(7'b1110000, first ? "R5" : "R7");
                j++;
            end
            for (int i = 0; i <= r; i++) begin
                push(7'b0100000, "R5");
                j++;
            end
            ks = kpos - 1;
            if (!(ks < k_rise + busy)) begin
                push(7'b1110010, done_tag);
                break;
            end else if (j >= TMO) begin
                push(7'b1110011, "R8");
                break;
            end
            first = 1'b0;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (poke) begin
            // R2: a request while busy must change nothing at the pins.
            repeat (3) @(posedge clk);
            #1;
            req_addr = ~a; req_data = ~d; req_valid = 1'b1;
            @(posedge clk); #1;
            req_valid = 1'b0; req_addr = a; req_data = d;
        end
        wait (exp_q.size() == 0);
        repeat (3) @(posedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        checking = 1'b1;                                    // R1 idle checks
        repeat (4) @(posedge clk);
        run_write(16'h1234, 8'hA5, 0, 0, 0, 0, 0, 0,      8'h00, 1'b0, "R6");
        run_write(16'h0042, 8'h3C, 1, 3, 1, 2, 2, 30,     8'h00, 1'b0, "R6");
        run_write(16'h7FFF, 8'hC3, 2, 5, 2, 3, 4, 55,     8'h00, 1'b1, "R6");
        run_write(16'h0101, 8'h81, 0, 1, 0, 1, 1, 20,     8'h55, 1'b0, "R10");
        run_write(16'h2222, 8'hF0, 1, 1, 1, 3, 2, 100000, 8'h00, 1'b0, "R8");
        run_write(16'h3333, 8'h0F, 0, 2, 1, 0, 1, 10,     8'h7F, 1'b0, "R6");
        repeat (5) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule